// File: doc/BRIEF.md
# Multiplexer-Based Configurable Logic Cell

This block is a purely combinational logic cell built from multiplexers. Two first-stage 2:1 multiplexers, the low leg and the high leg, each take two data inputs and a select. A two-input OR gate combines two group-enable inputs. Its result steers a final 2:1 multiplexer that passes either the low-leg output or the high-leg output to the single output `y`.

The cell has no fixed function. A function is chosen by wiring each of its eight inputs either to a user signal or to a constant 0 or 1. With suitable tie-offs, each leg can act as a buffer, an inverter, an AND, an OR, or an AND with one input inverted. The whole cell can produce every function of two variables and many functions of three or four variables. It holds no state, and the output follows the inputs at once.

Top module: `mux_logic_cell`

## Requirements
- R1: When `grp_en0` or `grp_en1` (or both) is 1, `y` equals the high-leg output. When both are 0, `y` equals the low-leg output.
- R2: In each leg, a select of 0 passes `*_d0` and a select of 1 passes `*_d1`.
- R3: The cell holds no state. The same input vector always gives the same `y`, whatever vectors came before it.
- R4: When a multiplexer's two data inputs are equal, its output is that value whatever its select. In particular, when all four leg data inputs carry one value, `y` carries it.
- R5: The low leg with `grp_en0 = grp_en1 = 0` gives each of these functions of variables P and Q:
  - BUF(P): tie `lo_d0=0`, `lo_d1=1`, `lo_sel=P`.
  - INV(P): tie `lo_d0=1`, `lo_d1=0`, `lo_sel=P`.
  - AND: tie `lo_d0=0`, `lo_d1=Q`, `lo_sel=P`.
  - OR: tie `lo_d0=Q`, `lo_d1=1`, `lo_sel=P`.
  - P·Q': tie `lo_d0=P`, `lo_d1=0`, `lo_sel=Q`.
  - P'·Q: tie `lo_d0=Q`, `lo_d1=0`, `lo_sel=P`.
- R6: With `lo_d0=D`, `lo_d1=1`, `hi_d0=D`, `hi_d1=1`, `lo_sel=C`, `hi_sel=A`, `grp_en0=0` and `grp_en1=B`, `y` equals A·B + B'·C + D for all 16 values of A, B, C and D.
- R7: With the low leg tied to constant 1, the high leg set to INV(Q) (`hi_d0=1`, `hi_d1=0`, `hi_sel=Q`), `grp_en0=P` and `grp_en1=0`, `y` equals NAND(P, Q).
- R8: Every one of the 16 two-input functions f(X, Y) is produced when each leg's select is tied to Y, each leg's data inputs are tied to the cofactor constants of f, and X drives one group enable while the other is held at 0. The cofactor constants are: `*_d0 = f(x, 0)` and `*_d1 = f(x, 1)`, with x = 0 for the low leg and x = 1 for the high leg. This holds whichever group enable carries X.
- R9: `y` is never unknown while all inputs are 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lo_d0 | input | 1 | Low leg data input chosen by select 0 |
| lo_d1 | input | 1 | Low leg data input chosen by select 1 |
| lo_sel | input | 1 | Low leg select |
| hi_d0 | input | 1 | High leg data input chosen by select 0 |
| hi_d1 | input | 1 | High leg data input chosen by select 1 |
| hi_sel | input | 1 | High leg select |
| grp_en0 | input | 1 | First input of the OR that picks the high leg |
| grp_en1 | input | 1 | Second input of the OR that picks the high leg |
| y | output | 1 | Cell output |

## Verification
The hardest case to reach from the ports is a leg whose select would pick a different input but whose two data inputs are equal. The output must not depend on that select, and this only shows when stimulus deliberately sets both data pins alike while toggling the select. The bench gets there by sweeping all 256 input vectors, which includes every equal-data pairing under both select values. It also builds the tie-off vectors for all 16 two-variable functions from cofactor constants, which again places equal constants on many legs. The same table is then driven twice, once through each group enable, and revisited in a different order, so that any dependence on past vectors would show.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    // One first-stage leg: two data inputs and its select
    typedef struct packed {
        logic d0;
        logic d1;
        logic sel;
    } mux_leg_t;

    localparam int unsigned NUM_LEGS = 2;
    localparam int unsigned LEG_LO   = 0;
    localparam int unsigned LEG_HI   = 1;

endpackage

// File: rtl/mlc_mux2.sv
module mlc_mux2 #(
    parameter int unsigned WIDTH = 1
) (
    input  logic [WIDTH-1:0] d0,
    input  logic [WIDTH-1:0] d1,
    input  logic             sel,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] agree_d;
    logic [WIDTH-1:0] picked_d;

    always_comb begin
        // bits on which both data inputs agree ignore the select entirely
        agree_d  = ~(d0 ^ d1);
        picked_d = sel ? d1 : d0;
        y        = (agree_d & d0) | (~agree_d & picked_d);
    end

    // R9
    always_comb begin
        if (!$isunknown({d0, d1, sel})) begin
            mux_known_out_chk: assert (!$isunknown(y));
        end
    end

endmodule

// File: rtl/mlc_or_sel.sv
module mlc_or_sel (
    input  logic en_a,
    input  logic en_b,
    output logic pick_hi
);
    always_comb begin
        pick_hi = en_a | en_b;
    end

endmodule

// File: rtl/mux_logic_cell.sv
module mux_logic_cell (
    input  logic lo_d0,
    input  logic lo_d1,
    input  logic lo_sel,
    input  logic hi_d0,
    input  logic hi_d1,
    input  logic hi_sel,
    input  logic grp_en0,
    input  logic grp_en1,
    output logic y
);
    import mlc_pkg::*;

    mux_leg_t                legs_d [NUM_LEGS];
    logic     [NUM_LEGS-1:0] leg_y_d;
    logic                    pick_hi_d;

    always_comb begin
        legs_d[LEG_LO] = '{d0: lo_d0, d1: lo_d1, sel: lo_sel};
        legs_d[LEG_HI] = '{d0: hi_d0, d1: hi_d1, sel: hi_sel};
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        mlc_mux2 #(.WIDTH(1)) u_leg (
            .d0  (legs_d[g].d0),
            .d1  (legs_d[g].d1),
            .sel (legs_d[g].sel),
            .y   (leg_y_d[g])
        );
    end

    mlc_or_sel u_pick (
        .en_a    (grp_en0),
        .en_b    (grp_en1),
        .pick_hi (pick_hi_d)
    );

    mlc_mux2 #(.WIDTH(1)) u_out (
        .d0  (leg_y_d[LEG_LO]),
        .d1  (leg_y_d[LEG_HI]),
        .sel (pick_hi_d),
        .y   (y)
    );

    always_comb begin
        if (!$isunknown({lo_d0, lo_d1, lo_sel, hi_d0, hi_d1, hi_sel, grp_en0, grp_en1})) begin
            // R1
            hi_side_agree_chk: assert (!(grp_en0 || grp_en1) || hi_d0 != hi_d1 || y == hi_d0);
            // R1
            lo_side_agree_chk: assert ((grp_en0 || grp_en1) || lo_d0 != lo_d1 || y == lo_d0);
            // R4
            all_data_equal_chk: assert (!(lo_d0 == lo_d1 && hi_d0 == hi_d1 && lo_d0 == hi_d0) || y == lo_d0);
            // R9
            out_known_chk: assert (!$isunknown(y));
        end
    end

endmodule

// File: tb/mux_logic_cell_test.sv
module mux_logic_cell_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic lo_d0, lo_d1, lo_sel, hi_d0, hi_d1, hi_sel, grp_en0, grp_en1;
    logic y;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    mux_logic_cell uut (
        .lo_d0   (lo_d0),
        .lo_d1   (lo_d1),
        .lo_sel  (lo_sel),
        .hi_d0   (hi_d0),
        .hi_d1   (hi_d1),
        .hi_sel  (hi_sel),
        .grp_en0 (grp_en0),
        .grp_en1 (grp_en1),
        .y       (y)
    );

    // vector order: {lo_d0, lo_d1, lo_sel, hi_d0, hi_d1, hi_sel, grp_en0, grp_en1}
    task automatic drive(input logic [7:0] v);
        @(posedge clk);
        {lo_d0, lo_d1, lo_sel, hi_d0, hi_d1, hi_sel, grp_en0, grp_en1} = v;
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req);
        total++;
        if ($isunknown(y) || y !== exp) begin
            bad++;
            $display("FAIL %s: y=%b expected=%b vec=%b%b%b%b%b%b%b%b", req, y, exp,
                     lo_d0, lo_d1, lo_sel, hi_d0, hi_d1, hi_sel, grp_en0, grp_en1);
        end
    endtask

    // behavioural model: an indexed lookup over the four data pins
    function automatic logic model(input logic [7:0] v);
        logic [3:0] data;
        int         side;
        int         sub;
        data = {v[7], v[6], v[4], v[3]};
        side = (int'(v[1]) + int'(v[0]) > 0) ? 1 : 0;
        sub  = side ? int'(v[2]) : int'(v[5]);
        return data[3 - (side * 2 + sub)];
    endfunction

    logic [7:0] seen_out;

    initial begin
        {lo_d0, lo_d1, lo_sel, hi_d0, hi_d1, hi_sel, grp_en0, grp_en1} = '0;
        @(negedge clk);
        // settled state with all inputs low
        check(1'b0, "R9 initial");

        // R1 R2 R4 R9: full sweep against the model
        for (int i = 0; i < 256; i++) begin
            drive(i[7:0]);
            check(model(i[7:0]), "R1/R2 sweep");
        end
        for (int i = 0; i < 256; i++) begin
            drive(i[7:0]);
            // R4: equal data in the selected leg, opposite select value
            if (i[1] | i[0]) begin
                if (i[4] == i[3]) check(i[4], "R4 hi equal data");
            end else begin
                if (i[7] == i[6]) check(i[7], "R4 lo equal data");
            end
        end

        // R5: low leg function generator
        for (int p = 0; p < 2; p++) begin
            for (int q = 0; q < 2; q++) begin
                logic pb, qb;
                pb = p[0];
                qb = q[0];
                drive({1'b0, 1'b1, pb, 3'b000, 2'b00});  check(pb, "R5 BUF");
                drive({1'b1, 1'b0, pb, 3'b000, 2'b00});  check(~pb, "R5 INV");
                drive({1'b0, qb, pb, 3'b000, 2'b00});    check(pb & qb, "R5 AND");
                drive({qb, 1'b1, pb, 3'b000, 2'b00});    check(pb | qb, "R5 OR");
                drive({pb, 1'b0, qb, 3'b000, 2'b00});    check(pb & ~qb, "R5 AND-invB");
                drive({qb, 1'b0, pb, 3'b000, 2'b00});    check(~pb & qb, "R5 AND-invA");
            end
        end

        // R6: four-variable mapping
        for (int k = 0; k < 16; k++) begin
            logic a, b, c, d;
            {a, b, c, d} = k[3:0];
            drive({d, 1'b1, c, d, 1'b1, a, 1'b0, b});
            check((a & b) | (~b & c) | d, "R6 A.B+B'.C+D");
        end

        // R7: NAND
        for (int k = 0; k < 4; k++) begin
            logic p, q;
            {p, q} = k[1:0];
            drive({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, q, p, 1'b0});
            check(~(p & q), "R7 NAND");
        end

        // R8: all 16 two-input functions through either enable; R3 via repeat
        for (int pass = 0; pass < 3; pass++) begin
            for (int fn = 0; fn < 16; fn++) begin
                for (int k = 0; k < 4; k++) begin
                    int         kk;
                    logic [3:0] tt;
                    logic       x, yv, exp;
                    kk  = (pass == 2) ? (3 - k) : k;
                    tt  = fn[3:0];
                    {x, yv} = kk[1:0];
                    exp = tt[{x, yv}];
                    drive({tt[2'b00], tt[2'b01], yv, tt[2'b10], tt[2'b11], yv,
                           (pass == 1) ? 1'b0 : x, (pass == 1) ? x : 1'b0});
                    check(exp, (pass == 2) ? "R3 reverse order" : "R8 two-input function");
                end
            end
        end

        // R3: same vector after different histories
        seen_out = '0;
        for (int h = 0; h < 8; h++) begin
            drive(8'(h * 37 + 11));
            drive(8'hA5);
            seen_out[h] = y;
            check(model(8'hA5), "R3 history independence");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: y=%b expected=progress", y);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule